// File: doc/BRIEF.md
# PTP Event Frame Timestamp Capture

This block records the local time of precision-time event frames as they cross the receive and transmit boundaries of an Ethernet port. A free-running 64-bit time value is presented on every cycle. When a frame's start-of-frame strobe arrives and the frame qualifies, the time value is copied into a capture slot for that direction and the slot is flagged as valid.

Each direction owns exactly one slot. A valid slot refuses new captures until software reads its upper capture word. A low-word read has no side effect, so software reads low then high, and the high read re-arms the slot. Receive frames are screened by a classifier. It combines an Ethernet type match, a match on IPv4/UDP event-port traffic and a per-mode message selection. Transmit captures are taken for every marked frame that is presented while the transmit direction is enabled.

Software reaches the block through a small word-addressed register port. Read data is combinational, and the release side effect takes place on the clock edge that ends the read cycle.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset every register reads zero: both control words, the filter word, and all four capture words. Address map: 0 receive control, 1 transmit control, 2 filter, 3 receive low, 4 receive high, 5 transmit low, 6 transmit high. Address 7 always reads zero.
- R2: The layer-2 match holds when the Ethernet type is 0x88F7 and filter-word bit 0 (filter enable) and bit 1 (stamp enable) are both 1.
- R3: The layer-4 match holds for an IPv4 frame with protocol 17 and UDP destination port 319. When receive-control bit 5 is 1, the UDP source port must also be 319.
- R4: In mode 0 (receive-control bits 3:2), a frame qualifies when its PTP version is 1, the layer-4 match holds, and its message type equals receive-control bit 4 (0 selects Sync = 0, 1 selects Delay_Req = 1).
- R5: In mode 1, a frame qualifies when its PTP version is 2, the layer-2 or the layer-4 match holds, and its message type is an event type (0 to 3).
- R6: In mode 2 every receive frame qualifies. In mode 3 no frame qualifies.
- R7: A qualifying receive start-of-frame strobe, with receive-control bit 0 (enable) set and the slot empty, stores the time value present at that clock edge. Receive-control bit 1 (valid) reads 1 from the next cycle on.
- R8: While a slot is valid, further strobes in that direction leave the captured value and the valid bit unchanged.
- R9: Reading the receive high word clears the receive valid bit on the edge that ends the read. Reading the low word leaves it set.
- R10: A transmit start-of-frame strobe with transmit-control bit 0 set and the slot empty captures the time value. Transmit-control bit 1 shows valid, the same lock applies, and reading the transmit high word releases the slot.
- R11: With the enable bit of a direction cleared, strobes in that direction capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current local time value |
| rx_sof | input | 1 | Receive start-of-frame strobe, one cycle |
| rx_ethertype | input | 16 | Parsed Ethernet type of the receive frame |
| rx_is_ipv4 | input | 1 | Receive frame carries IPv4 |
| rx_ip_proto | input | 8 | IP protocol number |
| rx_udp_src | input | 16 | UDP source port |
| rx_udp_dst | input | 16 | UDP destination port |
| rx_ptp_ver | input | 4 | PTP version field |
| rx_msg_type | input | 4 | PTP message type field |
| tx_sof | input | 1 | Start-of-frame strobe of a transmit frame marked for stamping |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
On every cycle, the checker confirms these slot properties in both directions. A qualified, enabled strobe into an empty slot stores the time value of that edge and sets valid. A valid slot that is not being released keeps its value and flag. A high-word read of a valid slot empties it. A disabled, empty slot stays empty. Whether a given header is qualified is outside the checker's view. It can only be shown by the bench's sweep across every mode, message selection, source-port option, layer-2 filter setting, version, message type and header shape. In that sweep the expected outcome of each frame is derived arithmetically from the rules. The bench's directed sequences also cover the ordering of low-then-high reads and the blocking of a second frame while a stamp is pending.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [15:0] ETYPE_PTP    = 16'h88F7;
    localparam logic [7:0]  PROTO_UDP    = 8'd17;
    localparam logic [15:0] PTP_EVT_PORT = 16'd319;
    localparam logic [3:0]  PTP_VER_1    = 4'd1;
    localparam logic [3:0]  PTP_VER_2    = 4'd2;
    localparam logic [3:0]  LAST_EVT_MSG = 4'd3;

    typedef enum logic [ADDR_W-1:0] {
        A_RX_CTRL = 3'd0,
        A_TX_CTRL = 3'd1,
        A_FILTER  = 3'd2,
        A_RX_LO   = 3'd3,
        A_RX_HI   = 3'd4,
        A_TX_LO   = 3'd5,
        A_TX_HI   = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        MODE_V1_L4  = 2'd0,
        MODE_V2_EVT = 2'd1,
        MODE_ALL    = 2'd2,
        MODE_NONE   = 2'd3
    } rx_mode_e;

    typedef struct packed {
        logic [15:0] ethertype;
        logic        is_ipv4;
        logic [7:0]  ip_proto;
        logic [15:0] udp_src;
        logic [15:0] udp_dst;
        logic [3:0]  ptp_ver;
        logic [3:0]  msg_type;
    } rx_hdr_t;

    typedef struct packed {
        logic     en;
        rx_mode_e mode;
        logic     msg_sel;
        logic     src_chk;
    } rx_cfg_t;

    typedef struct packed {
        logic filt_en;
        logic stamp_en;
    } l2_cfg_t;

    function automatic logic is_event_msg(input logic [3:0] m);
        return m <= LAST_EVT_MSG;
    endfunction

endpackage

// File: rtl/ts_rx_classifier.sv
module ts_rx_classifier
    import ts_cap_pkg::*;
(
    input  rx_hdr_t hdr,
    input  rx_cfg_t cfg,
    input  l2_cfg_t l2cfg,
    output logic    qual
);
    logic l2_hit;
    logic l4_hit;
    logic src_ok;

    always_comb begin
        l2_hit = l2cfg.filt_en && l2cfg.stamp_en && (hdr.ethertype == ETYPE_PTP);
        src_ok = !cfg.src_chk || (hdr.udp_src == PTP_EVT_PORT);
        l4_hit = hdr.is_ipv4 && (hdr.ip_proto == PROTO_UDP)
                 && (hdr.udp_dst == PTP_EVT_PORT) && src_ok;
        unique case (cfg.mode)
            MODE_V1_L4:  qual = (hdr.ptp_ver == PTP_VER_1) && l4_hit
                                && (hdr.msg_type == {3'b000, cfg.msg_sel});
            MODE_V2_EVT: qual = (hdr.ptp_ver == PTP_VER_2) && (l2_hit || l4_hit)
                                && is_event_msg(hdr.msg_type);
            MODE_ALL:    qual = 1'b1;
            default:     qual = 1'b0;
        endcase
    end
endmodule

// File: rtl/ts_capture_slot.sv
module ts_capture_slot #(
    parameter int STAMP_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               strobe,
    input  logic               qual,
    input  logic               release_i,
    input  logic [STAMP_W-1:0] time_i,
    output logic               valid_o,
    output logic [STAMP_W-1:0] stamp_o
);
    logic take;

    assign take = en && strobe && qual && !valid_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            stamp_o <= '0;
        end else if (take) begin
            valid_o <= 1'b1;
            stamp_o <= time_i;
        end else if (release_i) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ts_csr.sv
module ts_csr
    import ts_cap_pkg::*;
#(
    parameter int STAMP_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               rx_valid,
    input  logic               tx_valid,
    input  logic [STAMP_W-1:0] rx_stamp,
    input  logic [STAMP_W-1:0] tx_stamp,
    output rx_cfg_t            rx_cfg,
    output logic               tx_en,
    output l2_cfg_t            l2cfg,
    output logic               rx_release,
    output logic               tx_release,
    output logic [WORD_W-1:0]  rdata
);
    localparam int HI_W = STAMP_W - WORD_W;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[WORD_W-1:6], wdata[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_cfg <= '{en: 1'b0, mode: MODE_V1_L4, msg_sel: 1'b0, src_chk: 1'b0};
            tx_en  <= 1'b0;
            l2cfg  <= '0;
        end else if (wr) begin
            unique case (addr)
                A_RX_CTRL: begin
                    rx_cfg.en      <= wdata[0];
                    rx_cfg.mode    <= rx_mode_e'(wdata[3:2]);
                    rx_cfg.msg_sel <= wdata[4];
                    rx_cfg.src_chk <= wdata[5];
                end
                A_TX_CTRL: tx_en <= wdata[0];
                A_FILTER: begin
                    l2cfg.filt_en  <= wdata[0];
                    l2cfg.stamp_en <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    assign rx_release = rd && (addr == A_RX_HI);
    assign tx_release = rd && (addr == A_TX_HI);

    always_comb begin
        unique case (addr)
            A_RX_CTRL: rdata = {26'd0, rx_cfg.src_chk, rx_cfg.msg_sel,
                                rx_cfg.mode, rx_valid, rx_cfg.en};
            A_TX_CTRL: rdata = {30'd0, tx_valid, tx_en};
            A_FILTER:  rdata = {30'd0, l2cfg.stamp_en, l2cfg.filt_en};
            A_RX_LO:   rdata = rx_stamp[WORD_W-1:0];
            A_RX_HI:   rdata = WORD_W'(rx_stamp[STAMP_W-1:WORD_W]);
            A_TX_LO:   rdata = tx_stamp[WORD_W-1:0];
            A_TX_HI:   rdata = WORD_W'(tx_stamp[STAMP_W-1:WORD_W]);
            default:   rdata = '0;
        endcase
    end

    if (HI_W > WORD_W || HI_W < 1) begin : g_bad_width
        initial $error("STAMP_W must lie between 33 and 64");
    end
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
    import ts_cap_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] time_now,
    input  logic              rx_sof,
    input  logic [15:0]       rx_ethertype,
    input  logic              rx_is_ipv4,
    input  logic [7:0]        rx_ip_proto,
    input  logic [15:0]       rx_udp_src,
    input  logic [15:0]       rx_udp_dst,
    input  logic [3:0]        rx_ptp_ver,
    input  logic [3:0]        rx_msg_type,
    input  logic              tx_sof,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    rx_hdr_t           hdr;
    rx_cfg_t           rx_cfg;
    l2_cfg_t           l2cfg;
    logic              tx_en;
    logic              rx_en;
    logic              rx_qual;
    logic              rx_release;
    logic              tx_release;
    logic              rx_valid;
    logic              tx_valid;
    logic [TIME_W-1:0] rx_stamp;
    logic [TIME_W-1:0] tx_stamp;

    assign hdr = '{ethertype: rx_ethertype, is_ipv4: rx_is_ipv4,
                   ip_proto: rx_ip_proto, udp_src: rx_udp_src,
                   udp_dst: rx_udp_dst, ptp_ver: rx_ptp_ver,
                   msg_type: rx_msg_type};
    assign rx_en = rx_cfg.en;

    ts_csr #(.STAMP_W(TIME_W)) u_csr (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rx_valid(rx_valid), .tx_valid(tx_valid),
        .rx_stamp(rx_stamp), .tx_stamp(tx_stamp), .rx_cfg(rx_cfg),
        .tx_en(tx_en), .l2cfg(l2cfg), .rx_release(rx_release),
        .tx_release(tx_release), .rdata(reg_rdata)
    );

    ts_rx_classifier u_cls (
        .hdr(hdr), .cfg(rx_cfg), .l2cfg(l2cfg), .qual(rx_qual)
    );

    ts_capture_slot #(.STAMP_W(TIME_W)) u_rx_slot (
        .clk(clk), .rst(rst), .en(rx_en), .strobe(rx_sof), .qual(rx_qual),
        .release_i(rx_release), .time_i(time_now),
        .valid_o(rx_valid), .stamp_o(rx_stamp)
    );

    ts_capture_slot #(.STAMP_W(TIME_W)) u_tx_slot (
        .clk(clk), .rst(rst), .en(tx_en), .strobe(tx_sof), .qual(1'b1),
        .release_i(tx_release), .time_i(time_now),
        .valid_o(tx_valid), .stamp_o(tx_stamp)
    );
endmodule

// File: rtl/ts_cap_chk.sv
module ts_cap_chk #(
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [TIME_W-1:0] time_now,
    input logic              rx_sof,
    input logic              rx_qual,
    input logic              rx_en,
    input logic              rx_valid,
    input logic [TIME_W-1:0] rx_stamp,
    input logic              tx_sof,
    input logic              tx_en,
    input logic              tx_valid,
    input logic [TIME_W-1:0] tx_stamp,
    input logic              reg_rd,
    input logic [2:0]        reg_addr
);
    logic rx_hi_rd;
    logic tx_hi_rd;
    assign rx_hi_rd = reg_rd && (reg_addr == 3'd4);
    assign tx_hi_rd = reg_rd && (reg_addr == 3'd6);

    // R7
    rx_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_sof && rx_qual && rx_en && !rx_valid)
        |=> (rx_valid && rx_stamp == $past(time_now)));

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_hi_rd) |=> (rx_valid && $stable(rx_stamp)));

    // R9
    rx_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_hi_rd) |=> !rx_valid);

    // R11
    rx_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !rx_valid) |=> !rx_valid);

    // R10
    tx_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_sof && tx_en && !tx_valid)
        |=> (tx_valid && tx_stamp == $past(time_now)));

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_hi_rd) |=> (tx_valid && $stable(tx_stamp)));

    // R10
    tx_release_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_hi_rd) |=> !tx_valid);

    // R11
    tx_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !tx_valid) |=> !tx_valid);
endmodule

bind ts_capture_unit ts_cap_chk #(.TIME_W(TIME_W)) u_chk (
    .clk(clk), .rst(rst), .time_now(time_now), .rx_sof(rx_sof),
    .rx_qual(rx_qual), .rx_en(rx_en), .rx_valid(rx_valid),
    .rx_stamp(rx_stamp), .tx_sof(tx_sof), .tx_en(tx_en),
    .tx_valid(tx_valid), .tx_stamp(tx_stamp), .reg_rd(reg_rd),
    .reg_addr(reg_addr)
);

// File: tb/tb_ts_capture_unit.sv
`timescale 1ns/1ps
module tb_ts_capture_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_now = '0;
    logic        rx_sof = 1'b0;
    logic [15:0] rx_ethertype = '0;
    logic        rx_is_ipv4 = 1'b0;
    logic [7:0]  rx_ip_proto = '0;
    logic [15:0] rx_udp_src = '0;
    logic [15:0] rx_udp_dst = '0;
    logic [3:0]  rx_ptp_ver = '0;
    logic [3:0]  rx_msg_type = '0;
    logic        tx_sof = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ts_capture_unit dut (
        .clk(clk), .rst(rst), .time_now(time_now), .rx_sof(rx_sof),
        .rx_ethertype(rx_ethertype), .rx_is_ipv4(rx_is_ipv4),
        .rx_ip_proto(rx_ip_proto), .rx_udp_src(rx_udp_src),
        .rx_udp_dst(rx_udp_dst), .rx_ptp_ver(rx_ptp_ver),
        .rx_msg_type(rx_msg_type), .tx_sof(tx_sof), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // path: 0 L2 frame, 1 L4 good, 2 L4 bad source, 3 L4 bad dest, 4 TCP
    task automatic rx_frame(input int path, input logic [3:0] ver,
                            input logic [3:0] msg, input logic [63:0] t);
        @(negedge clk);
        rx_ethertype = (path == 0) ? 16'h88F7 : 16'h0800;
        rx_is_ipv4   = (path != 0);
        rx_ip_proto  = (path == 4) ? 8'd6 : 8'd17;
        rx_udp_src   = (path == 2) ? 16'd1000 : 16'd319;
        rx_udp_dst   = (path == 3) ? 16'd320 : 16'd319;
        rx_ptp_ver   = ver;
        rx_msg_type  = msg;
        time_now     = t;
        rx_sof       = 1'b1;
        @(posedge clk); #1;
        rx_sof = 1'b0;
    endtask

    task automatic tx_frame(input logic [63:0] t);
        @(negedge clk);
        time_now = t; tx_sof = 1'b1;
        @(posedge clk); #1;
        tx_sof = 1'b0;
    endtask

    function automatic logic model_qual(input int mode, input int msel, input int sck,
                                        input int l2c, input int ver, input int msg,
                                        input int path);
        logic l2, l4;
        l2 = (path == 0) && (l2c == 3);
        l4 = (path == 1) || (path == 2 && sck == 0);
        case (mode)
            0: return (ver == 1) && l4 && (msg == msel);
            1: return (ver == 2) && (l2 || l4) && (msg <= 3);
            2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] t;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state of every address, incl. unmapped 7
        for (int a = 0; a < 8; a++) begin
            reg_read(3'(a), d);
            check("R1 reset read", 64'(d), 64'd0);
        end

        // R11 receive disabled: mode ALL but enable 0
        reg_write(3'd0, 32'h8);
        rx_frame(0, 4'd2, 4'd0, 64'h1111_0000_2222_0000);
        reg_read(3'd0, d);
        check("R11 rx disabled no valid", 64'(d[1]), 64'd0);

        // R7 R8 R9 capture, lock, low read, high read release
        reg_write(3'd0, 32'h9);
        rx_frame(4, 4'd0, 4'd9, 64'hAAAA_0001_BBBB_0001);
        rx_frame(0, 4'd2, 4'd0, 64'hAAAA_0002_BBBB_0002);
        reg_read(3'd0, d);
        check("R7 rx valid set", 64'(d[1]), 64'd1);
        reg_read(3'd3, d);
        check("R8 rx low holds first stamp", 64'(d), 64'hBBBB_0001);
        reg_read(3'd0, d);
        check("R9 low read keeps valid", 64'(d[1]), 64'd1);
        reg_read(3'd4, d);
        check("R8 rx high holds first stamp", 64'(d), 64'hAAAA_0001);
        reg_read(3'd0, d);
        check("R9 high read clears valid", 64'(d[1]), 64'd0);
        rx_frame(1, 4'd1, 4'd1, 64'hAAAA_0003_BBBB_0003);
        reg_read(3'd3, d);
        check("R9 rearmed capture low", 64'(d), 64'hBBBB_0003);
        reg_read(3'd4, d);
        check("R9 rearmed capture high", 64'(d), 64'hAAAA_0003);

        // R10 R11 transmit slot
        tx_frame(64'h5555_0000_6666_0000);
        reg_read(3'd1, d);
        check("R11 tx disabled no valid", 64'(d[1]), 64'd0);
        reg_write(3'd1, 32'h1);
        tx_frame(64'h5555_0001_6666_0001);
        tx_frame(64'h5555_0002_6666_0002);
        reg_read(3'd1, d);
        check("R10 tx valid", 64'(d), 64'h3);
        reg_read(3'd5, d);
        check("R10 tx low first stamp", 64'(d), 64'h6666_0001);
        reg_read(3'd6, d);
        check("R10 tx high first stamp", 64'(d), 64'h5555_0001);
        reg_read(3'd1, d);
        check("R10 tx released", 64'(d), 64'h1);
        tx_frame(64'h5555_0003_6666_0003);
        reg_read(3'd6, d);
        check("R10 tx rearmed high", 64'(d), 64'h5555_0003);

        // R2 R3 R4 R5 R6 R7 classifier sweep
        for (int mode = 0; mode < 4; mode++)
        for (int msel = 0; msel < 2; msel++)
        for (int sck = 0; sck < 2; sck++)
        for (int l2c = 0; l2c < 4; l2c++) begin
            reg_write(3'd2, 32'(l2c));
            reg_write(3'd0, 32'((sck << 5) | (msel << 4) | (mode << 2) | 1));
            for (int v = 1; v < 4; v++)
            for (int mi = 0; mi < 5; mi++)
            for (int path = 0; path < 5; path++) begin
                int msg;
                logic e;
                msg = (mi == 4) ? 8 : mi;
                t = {8'hC0, 8'(mode * 16 + msel * 8 + sck * 4 + l2c), 8'(v), 8'(msg),
                     8'(path), 8'h5A, 16'(n_cmp)};
                e = model_qual(mode, msel, sck, l2c, v, msg, path);
                rx_frame(path, 4'(v), 4'(msg), t);
                reg_read(3'd0, d);
                check($sformatf("R2 R3 R4 R5 R6 qualify m%0d s%0d c%0d f%0d v%0d t%0d p%0d",
                      mode, msel, sck, l2c, v, msg, path), 64'(d[1]), 64'(e));
                if (d[1]) begin
                    reg_read(3'd3, d);
                    check("R7 sweep low", 64'(d), 64'(t[31:0]));
                    reg_read(3'd4, d);
                    check("R7 sweep high", 64'(d), 64'(t[63:32]));
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule